// File: doc/BRIEF.md
# Byte-Pair Phase Recovery for Unmarked 16-bit Samples

This block sits behind a byte receiver on a link that carries 16-bit samples as two bytes each, with no marker byte. It finds which byte of each pair is the low byte by looking at bit activity. Low-order bytes of a real signal toggle far more often than high-order bytes. For every accepted byte the block counts the transitions between adjacent data bits. It adds that count into one of two sums, chosen by the byte's parity (even or odd position in the stream). At the end of each fixed window it compares the two sums and corrects the pairing phase if needed.

Bytes arrive as single-cycle strobes, at any rate up to one per clock. Pairs are rebuilt according to the current phase. Each finished pair is delivered as a 16-bit word with a one-cycle valid pulse. When a byte is lost in transit, the phase slips. Within at most one window the block realigns, drops the broken partial pair and resumes clean pairing.

Top module: `pair_phase_align`

## Requirements
- R1: After reset, sample_valid is 0, sample_data is 0 and low_parity is 0, so the first accepted byte (even position) is taken as a low byte.
- R2: The activity of a byte is the number of positions i in 0..6 where data bit i differs from bit i+1, a value from 0 to 7.
- R3: Activity is summed separately for even-position and odd-position bytes. Position is counted over accepted bytes from reset. Each window covers 128 accepted bytes (64 pairs), and both sums restart from zero after each window.
- R4: At the end of a window, low_parity toggles only if the sum for the current high parity is strictly greater than the sum for the current low parity. The window's last byte is included in that sum. On a tie, or when the low parity sum is larger, low_parity is held. low_parity changes at no other time.
- R5: A sample is delivered as sample_data = {high byte, low byte}. sample_valid is high for exactly one cycle, the cycle after the high byte is accepted.
- R6: A byte whose position parity equals low_parity is stored as a pending low byte. A byte of the other parity with no pending low byte is discarded and produces no sample.
- R7: When low_parity toggles, any pending low byte is dropped. The next byte of the new low parity starts the next sample.
- R8: Cycles with byte_valid low change nothing. Bytes may be accepted on consecutive cycles.
- R9: sample_data holds its last delivered value between valid pulses.
- R10: When the last byte of a window completes a pair, that sample is built with the old phase and delivered. The phase toggle decided by the same byte takes effect for the following bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe: byte_data carries a received byte |
| byte_data | input | 8 | Received data byte |
| sample_valid | output | 1 | One-cycle pulse: sample_data holds a new sample |
| sample_data | output | 16 | Rebuilt sample, high byte in bits 15:8 |
| low_parity | output | 1 | Position parity currently treated as the low byte (0 = even) |

## Verification
Two events can land on the same clock: the byte that closes an activity window can also be the high byte that completes a pair. That same byte can then trigger a phase toggle. The bench provokes this with a first window whose odd bytes are busy (0x55) and whose even bytes are quiet (0x00). The closing odd byte then emits a sample and reverses the phase together. The bench judges it against a behavioural model updated on every byte. The model expects the sample built with the old phase, then the next even byte discarded, then the pairing to restart on the odd parity. Later windows cover a tie, a one-count margin and a stream with a dropped byte.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
    localparam int BYTE_W = 8;
    localparam int ACT_W  = $clog2(BYTE_W);
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ppa_activity.sv
module ppa_activity
    import ppa_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);
    logic [W-2:0] edge_w;

    for (genvar g = 0; g < W - 1; g++) begin : g_edge
        assign edge_w[g] = bits[g] ^ bits[g+1];
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < W - 1; i++) begin
            count = count + CW'(edge_w[i]);
        end
    end

    // R2: zero activity exactly for a constant byte
    always_comb begin
        a_r2_flat_zero: assert ((count == '0) == ((bits == '0) || (bits == '1)));
    end
endmodule

// File: rtl/ppa_window.sv
module ppa_window
    import ppa_pkg::*;
#(
    parameter int PAIRS = 64,
    parameter int AW    = ACT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic [AW-1:0] activity,
    output logic          byte_par,
    output logic          low_par,
    output logic          flip
);
    localparam int LAST    = 2 * PAIRS - 1;
    localparam int CNT_W   = $clog2(2 * PAIRS);
    localparam int MAX_SUM = PAIRS * ((1 << AW) - 1);
    localparam int ACC_W   = $clog2(MAX_SUM + 1);

    typedef struct packed {
        logic [CNT_W-1:0]         cnt;
        logic [1:0][ACC_W-1:0]    acc;
        logic                     phase;
    } win_t;

    win_t st_d, st_q;
    logic [1:0][ACC_W-1:0] sum_n;

    always_comb begin
        st_d  = st_q;
        flip  = 1'b0;
        sum_n = st_q.acc;
        if (byte_valid) begin
            sum_n[st_q.cnt[0]] = st_q.acc[st_q.cnt[0]] + ACC_W'(activity);
            if (st_q.cnt == CNT_W'(LAST)) begin
                flip       = sum_n[~st_q.phase] > sum_n[st_q.phase];
                st_d.phase = st_q.phase ^ flip;
                st_d.acc   = '0;
                st_d.cnt   = '0;
            end else begin
                st_d.acc = sum_n;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_par = st_q.cnt[0];
    assign low_par  = st_q.phase;

    // R4: phase only moves on a window-closing byte
    a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && st_q.cnt == CNT_W'(LAST)) |=> $stable(st_q.phase));

    // R3: sums never exceed one window's worth of activity
    a_r3_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc[0] <= ACC_W'(MAX_SUM)) && (st_q.acc[1] <= ACC_W'(MAX_SUM)));

    // R3: sums restart after every window
    a_r3_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && st_q.cnt == CNT_W'(LAST)) |=> (st_q.acc == '0 && st_q.cnt == '0));
endmodule

// File: rtl/ppa_assemble.sv
module ppa_assemble
    import ppa_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_valid,
    input  byte_t                 byte_data,
    input  logic                  is_low,
    input  logic                  flush,
    output logic                  sample_valid,
    output logic [2*BYTE_W-1:0]   sample_data
);
    typedef struct packed {
        logic                 have_low;
        byte_t                low_byte;
        logic                 valid;
        logic [2*BYTE_W-1:0]  sample;
    } asm_t;

    asm_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (byte_valid) begin
            if (is_low) begin
                st_d.low_byte = byte_data;
                st_d.have_low = 1'b1;
            end else if (st_q.have_low) begin
                st_d.valid    = 1'b1;
                st_d.sample   = {byte_data, st_q.low_byte};
                st_d.have_low = 1'b0;
            end
        end
        if (flush) st_d.have_low = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_valid = st_q.valid;
    assign sample_data  = st_q.sample;

    // R5: valid is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R5: a pulse always follows an accepted byte
    a_r5_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(byte_valid));

    // R7: a phase toggle leaves no pending low byte
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !st_q.have_low);

    // R9: sample holds when no pulse
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> $stable(st_q.sample) || $past(!rst_n));
endmodule

// File: rtl/pair_phase_align.sv
module pair_phase_align
    import ppa_pkg::*;
#(
    parameter int PAIRS_PER_WINDOW = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        sample_valid,
    output logic [15:0] sample_data,
    output logic        low_parity
);
    logic [ACT_W-1:0] activity;
    logic             byte_par;
    logic             low_par;
    logic             flip;

    ppa_activity #(.W(BYTE_W), .CW(ACT_W)) i_activity (
        .bits  (byte_data),
        .count (activity)
    );

    ppa_window #(.PAIRS(PAIRS_PER_WINDOW), .AW(ACT_W)) i_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .activity   (activity),
        .byte_par   (byte_par),
        .low_par    (low_par),
        .flip       (flip)
    );

    ppa_assemble i_assemble (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .is_low       (byte_par == low_par),
        .flush        (flip),
        .sample_valid (sample_valid),
        .sample_data  (sample_data)
    );

    assign low_parity = low_par;
endmodule

// File: tb/test_pair_phase_align.sv
module test_pair_phase_align;
    localparam int PAIRS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        sample_valid;
    logic [15:0] sample_data;
    logic        low_parity;

    int checks = 0;
    int errors = 0;
    string ctx = "R1";

    // reference model state
    int wc = 0;
    int ph = 0;
    int have = 0;
    int sums[2];
    logic [7:0]  low_b = 8'h00;
    logic        exp_v = 1'b0;
    logic [15:0] exp_s = 16'h0000;
    int lfsr = 16'hACE1;

    always #10 clk = ~clk;

    pair_phase_align #(.PAIRS_PER_WINDOW(PAIRS)) i_pair_phase_align (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .sample_valid(sample_valid), .sample_data(sample_data), .low_parity(low_parity)
    );

    function automatic int act_of(logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 7; i++) if (b[i] != b[i+1]) n++;
        return n;
    endfunction

    task automatic compare();
        checks++;
        if (sample_valid !== exp_v) begin
            errors++;
            $display("FAIL %s R5 sample_valid actual %0d expected %0d", ctx, sample_valid, exp_v);
        end
        checks++;
        if (sample_data !== exp_s) begin
            errors++;
            $display("FAIL %s R9 sample_data actual %h expected %h", ctx, sample_data, exp_s);
        end
        checks++;
        if (low_parity !== ph[0]) begin
            errors++;
            $display("FAIL %s R4 low_parity actual %0d expected %0d", ctx, low_parity, ph);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] d);
        int par;
        @(negedge clk);
        compare();
        byte_valid = v;
        byte_data  = d;
        exp_v = 1'b0;
        if (v) begin
            par = wc % 2;
            if (par == ph) begin
                low_b = d;
                have  = 1;
            end else if (have != 0) begin
                exp_v = 1'b1;
                exp_s = {d, low_b};
                have  = 0;
            end
            sums[par] += act_of(d);
            wc++;
            if (wc == 2 * PAIRS) begin
                if (sums[1-ph] > sums[ph]) begin
                    ph   = 1 - ph;
                    have = 0;
                end
                sums[0] = 0;
                sums[1] = 0;
                wc = 0;
            end
        end
    endtask

    function automatic logic [7:0] next_rand();
        lfsr = ((lfsr << 1) ^ ((lfsr >> 15) & 1) ^ ((lfsr >> 13) & 1)
                ^ ((lfsr >> 12) & 1) ^ ((lfsr >> 10) & 1)) & 16'hFFFF;
        return lfsr[7:0];
    endfunction

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lo;
        logic [7:0] hi;
        sums[0] = 0;
        sums[1] = 0;
        // R1: reset state
        ctx = "R1";
        repeat (3) step(1'b0, 8'h00);
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        step(1'b0, 8'h00);

        // window 1: odd bytes busy, even quiet, idle gaps (R8)
        ctx = "R5";
        for (int k = 0; k < PAIRS; k++) begin
            if (k == PAIRS - 1) ctx = "R10";
            step(1'b1, 8'h00);
            if (k % 3 == 0) begin ctx = (k == PAIRS - 1) ? "R10" : "R8"; step(1'b0, 8'hFF); end
            step(1'b1, 8'h55);
            if (k < PAIRS - 1) ctx = "R5";
        end
        ctx = "R10";
        repeat (2) step(1'b0, 8'h00);

        // window 2: after the toggle, even byte discarded, odd starts pairs
        ctx = "R7";
        for (int k = 0; k < PAIRS; k++) begin
            if (k == 2) ctx = "R6";
            step(1'b1, 8'h00);
            step(1'b1, 8'h55);
        end

        // window 3: equal activity, phase must hold
        ctx = "R4";
        for (int k = 0; k < 2 * PAIRS; k++) step(1'b1, 8'hA5);
        repeat (2) step(1'b0, 8'h00);

        // window 4: high parity wins by exactly one count
        ctx = "R2";
        for (int k = 0; k < PAIRS; k++) begin
            step(1'b1, (k == 10) ? 8'h02 : 8'h03);
            step(1'b1, 8'h01);
        end
        repeat (2) step(1'b0, 8'h00);

        // realistic samples with lost bytes, back-to-back
        ctx = "R3";
        for (int k = 0; k < 3 * PAIRS; k++) begin
            lo = next_rand();
            hi = {7'b0, lo[0]};
            if (k != 40 && k != 250) step(1'b1, lo);
            step(1'b1, hi);
            if (k % 7 == 0) begin ctx = "R8"; step(1'b0, 8'h5A); ctx = "R3"; end
        end
        repeat (3) step(1'b0, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule